// File: doc/BRIEF.md
# Port Event Latch and Interrupt Aggregator

This block records status changes and fault strobes from a set of power ports so that a host can find them later, even when the live status has already moved on. The block watches each port's power-good and power-enable levels and flags every change in either direction. It also latches single-cycle fault strobes: load removal, extended overcurrent, start timeout and supply faults. Each event register can be read at two neighbouring addresses. The even address only reads the register. The odd address reads it and then empties it.

A summary register holds one bit per event class. A writable mask selects which classes may pull the shared interrupt line low. The line is open-drain: it is driven low while any enabled class is pending and is left floating otherwise. A command write with the top bit set empties every event register in one step. An event that arrives in the same cycle as any clear is kept.

Top module: `event_irq_agg`

## Requirements
- R1: A change of a port's power-good input in either direction, relative to its value in the previous cycle, sets that port's bit in field [7:4] of the power event register (port n at bit 4+n) on the next clock edge.
- R2: A change of a port's power-enable input in either direction sets that port's bit in field [3:0] of the power event register (port n at bit n).
- R3: The power event register reads at address 0x02 with no side effect. A read at 0x03 returns the same value and empties the register.
- R4: A load-removal shutdown strobe for port n sets bit 4+n of the fault event register (read-only at 0x04, clear-on-read at 0x05).
- R5: An extended-overcurrent shutdown strobe for port n sets bit n of the fault event register.
- R6: A start-timeout strobe for port n sets bit n, and supply fault line k sets bit 4+k, of the timing/supply event register (read-only at 0x06, clear-on-read at 0x07).
- R7: The summary register at 0x00 is read-only. Bit 0 is the OR of the power-enable changes, bit 1 of the power-good changes, bit 2 of the overcurrent events, bit 3 of the load-removal events, bit 4 of the start timeouts and bit 5 of the supply faults. Bits 7:6 read 0.
- R8: The mask register at 0x01 is written and read back as a full byte. The interrupt line is driven to 0 exactly when the AND of the summary and the mask is nonzero, and is released (high impedance) otherwise.
- R9: A write to 0x1A with bit 7 set empties all event registers, and therefore the summary and the interrupt. A write there with bit 7 clear changes nothing.
- R10: An event that arrives in the same cycle as a clear-on-read or a global clear is still set after that clock edge.
- R11: After reset all event registers and the mask are 0 and the interrupt line is released.
- R12: Read data appears on the clock edge that samples the read strobe and holds until the next read. Any unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pgIn | input | 4 | Live power-good level per port |
| penIn | input | 4 | Live power-enable level per port |
| ldDiscStb | input | 4 | Per-port shutdown strobe for load removal |
| ocFltStb | input | 4 | Per-port shutdown strobe for extended overcurrent |
| startTmoStb | input | 4 | Per-port strobe for start timeout |
| supFltStb | input | 4 | Supply fault strobes |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | 8 | Read address |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Write address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| irqN | output | 1 | Open-drain interrupt, low when an enabled event is pending |

## Verification
Two kinds of operation can fall in the same cycle: a clear (a clear-on-read, or the global command clear) and a new event for the register being cleared. The bench provokes this case on purpose. It toggles a power-good input, or fires a load-removal strobe, on the same clock edge as a read at 0x03 or a command write at 0x1A. It then checks that the clearing read returned the old contents, that the old bits are gone, and that the new bit survived. A behavioural model, updated on every clock, predicts both the read data and the interrupt level, so any mismatch in that cycle or a later one is reported.

// File: rtl/event_irq_agg_pkg.sv
package event_irq_agg_pkg;

  localparam int ADDR_W  = 8;
  localparam int CLR_BIT = 7;

  localparam logic [ADDR_W-1:0] A_SUMMARY = 8'h00;
  localparam logic [ADDR_W-1:0] A_MASK    = 8'h01;
  localparam logic [ADDR_W-1:0] A_PWR_RO  = 8'h02;
  localparam logic [ADDR_W-1:0] A_PWR_COR = 8'h03;
  localparam logic [ADDR_W-1:0] A_FLT_RO  = 8'h04;
  localparam logic [ADDR_W-1:0] A_FLT_COR = 8'h05;
  localparam logic [ADDR_W-1:0] A_TMO_RO  = 8'h06;
  localparam logic [ADDR_W-1:0] A_TMO_COR = 8'h07;
  localparam logic [ADDR_W-1:0] A_CMD     = 8'h1A;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SUM,
    SEL_MASK,
    SEL_PWR,
    SEL_FLT,
    SEL_TMO
  } rdSel_e;

  typedef struct packed {
    logic   corPwr;
    logic   corFlt;
    logic   corTmo;
    logic   clrAll;
    logic   maskWr;
    logic   rdLoad;
    rdSel_e rdSel;
  } evtStrb_t;

endpackage

// File: rtl/event_irq_agg_ctrl.sv
module event_irq_agg_ctrl
  import event_irq_agg_pkg::*;
(
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrClrBit,
  output evtStrb_t          strb
);

  always_comb begin
    strb        = '0;
    strb.rdSel  = SEL_NONE;
    strb.rdLoad = rdEn;
    if (rdEn) begin
      unique case (rdAddr)
        A_SUMMARY: strb.rdSel = SEL_SUM;
        A_MASK:    strb.rdSel = SEL_MASK;
        A_PWR_RO:  strb.rdSel = SEL_PWR;
        A_PWR_COR: begin strb.rdSel = SEL_PWR; strb.corPwr = 1'b1; end
        A_FLT_RO:  strb.rdSel = SEL_FLT;
        A_FLT_COR: begin strb.rdSel = SEL_FLT; strb.corFlt = 1'b1; end
        A_TMO_RO:  strb.rdSel = SEL_TMO;
        A_TMO_COR: begin strb.rdSel = SEL_TMO; strb.corTmo = 1'b1; end
        default:   strb.rdSel = SEL_NONE;
      endcase
    end
    if (wrEn) begin
      if (wrAddr == A_MASK) strb.maskWr = 1'b1;
      if (wrAddr == A_CMD && wrClrBit) strb.clrAll = 1'b1;
    end
  end

endmodule

// File: rtl/event_irq_agg_dp.sv
module event_irq_agg_dp
  import event_irq_agg_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  evtStrb_t               strb,
  input  logic [NUM_PORTS-1:0]   pgIn,
  input  logic [NUM_PORTS-1:0]   penIn,
  input  logic [NUM_PORTS-1:0]   ldDiscStb,
  input  logic [NUM_PORTS-1:0]   ocFltStb,
  input  logic [NUM_PORTS-1:0]   startTmoStb,
  input  logic [NUM_PORTS-1:0]   supFltStb,
  input  logic [2*NUM_PORTS-1:0] wrData,
  output logic [2*NUM_PORTS-1:0] rdData,
  output logic                   irqAct
);

  localparam int REG_W = 2 * NUM_PORTS;
  localparam int SUM_W = 6;

  logic [NUM_PORTS-1:0] pgPrev, penPrev;
  logic [NUM_PORTS-1:0] pgChgNow, penChgNow;
  logic [REG_W-1:0]     evPwr, evFlt, evTmo;
  logic [REG_W-1:0]     setPwr, setFlt, setTmo;
  logic [REG_W-1:0]     maskReg, summary;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign pgChgNow[p]  = pgIn[p] ^ pgPrev[p];
    assign penChgNow[p] = penIn[p] ^ penPrev[p];
  end

  assign setPwr = {pgChgNow, penChgNow};
  assign setFlt = {ldDiscStb, ocFltStb};
  assign setTmo = {supFltStb, startTmoStb};

  always_ff @(posedge clk) begin
    if (rst) begin
      pgPrev  <= '0;
      penPrev <= '0;
    end else begin
      pgPrev  <= pgIn;
      penPrev <= penIn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evPwr <= '0;
      evFlt <= '0;
      evTmo <= '0;
    end else begin
      evPwr <= ((strb.corPwr || strb.clrAll) ? '0 : evPwr) | setPwr;
      evFlt <= ((strb.corFlt || strb.clrAll) ? '0 : evFlt) | setFlt;
      evTmo <= ((strb.corTmo || strb.clrAll) ? '0 : evTmo) | setTmo;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              maskReg <= '0;
    else if (strb.maskWr) maskReg <= wrData;
  end

  always_comb begin
    summary    = '0;
    summary[0] = |evPwr[NUM_PORTS-1:0];
    summary[1] = |evPwr[REG_W-1:NUM_PORTS];
    summary[2] = |evFlt[NUM_PORTS-1:0];
    summary[3] = |evFlt[REG_W-1:NUM_PORTS];
    summary[4] = |evTmo[NUM_PORTS-1:0];
    summary[5] = |evTmo[REG_W-1:NUM_PORTS];
  end

  assign irqAct = |(summary[SUM_W-1:0] & maskReg[SUM_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) rdData <= '0;
    else if (strb.rdLoad) begin
      unique case (strb.rdSel)
        SEL_SUM:  rdData <= summary;
        SEL_MASK: rdData <= maskReg;
        SEL_PWR:  rdData <= evPwr;
        SEL_FLT:  rdData <= evFlt;
        SEL_TMO:  rdData <= evTmo;
        default:  rdData <= '0;
      endcase
    end
  end

  AST_PG_CHANGE_SETS: assert property (@(posedge clk) disable iff (rst)
    (pgChgNow != '0) |=> ((evPwr[REG_W-1:NUM_PORTS] & $past(pgChgNow)) == $past(pgChgNow))); // R1

  AST_COR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (strb.corPwr && setPwr == '0) |=> (evPwr == '0)); // R3

  AST_GLOBAL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (strb.clrAll && setPwr == '0 && setFlt == '0 && setTmo == '0)
      |=> (evPwr == '0 && evFlt == '0 && evTmo == '0)); // R9

  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (setFlt != '0) |=> ((evFlt & $past(setFlt)) == $past(setFlt))); // R10

  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (rst)
    !strb.maskWr |=> $stable(maskReg)); // R8

endmodule

// File: rtl/event_irq_agg.sv
module event_irq_agg
  import event_irq_agg_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_PORTS-1:0]   pgIn,
  input  logic [NUM_PORTS-1:0]   penIn,
  input  logic [NUM_PORTS-1:0]   ldDiscStb,
  input  logic [NUM_PORTS-1:0]   ocFltStb,
  input  logic [NUM_PORTS-1:0]   startTmoStb,
  input  logic [NUM_PORTS-1:0]   supFltStb,
  input  logic                   rdEn,
  input  logic [ADDR_W-1:0]      rdAddr,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [2*NUM_PORTS-1:0] wrData,
  output logic [2*NUM_PORTS-1:0] rdData,
  output logic                   irqN
);

  evtStrb_t strb;
  logic     irqAct;

  event_irq_agg_ctrl u_ctrl (
    .rdEn     (rdEn),
    .rdAddr   (rdAddr),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrClrBit (wrData[CLR_BIT]),
    .strb     (strb)
  );

  event_irq_agg_dp #(.NUM_PORTS(NUM_PORTS)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .pgIn        (pgIn),
    .penIn       (penIn),
    .ldDiscStb   (ldDiscStb),
    .ocFltStb    (ocFltStb),
    .startTmoStb (startTmoStb),
    .supFltStb   (supFltStb),
    .wrData      (wrData),
    .rdData      (rdData),
    .irqAct      (irqAct)
  );

  assign irqN = irqAct ? 1'b0 : 1'bz;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rdEn && rdAddr > A_TMO_COR) |=> (rdData == '0)); // R12

  AST_RD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> $stable(rdData)); // R12

endmodule

// File: tb/event_irq_agg_bench.sv
module event_irq_agg_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] pgIn = '0, penIn = '0, ldDiscStb = '0, ocFltStb = '0;
  logic [3:0] startTmoStb = '0, supFltStb = '0;
  logic       rdEn = 1'b0, wrEn = 1'b0;
  logic [7:0] rdAddr = '0, wrAddr = '0, wrData = '0;
  logic [7:0] rdData;
  wire        irqLine;

  pullup (irqLine);

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  event_irq_agg u_event_irq_agg (
    .clk(clk), .rst(rst), .pgIn(pgIn), .penIn(penIn),
    .ldDiscStb(ldDiscStb), .ocFltStb(ocFltStb),
    .startTmoStb(startTmoStb), .supFltStb(supFltStb),
    .rdEn(rdEn), .rdAddr(rdAddr), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdData(rdData), .irqN(irqLine)
  );

  // behavioural reference model
  bit   mPg[4], mPen[4], mLd[4], mOc[4], mTo[4], mSup[4];
  bit   lastPg[4], lastPen[4];
  int   mMask = 0;
  int   mRd = 0;

  function automatic int packPair(bit hi[4], bit lo[4]);
    int v = 0;
    for (int i = 0; i < 4; i++) v += (int'(hi[i]) << (4 + i)) + (int'(lo[i]) << i);
    return v;
  endfunction

  function automatic bit anyOf(bit a[4]);
    for (int i = 0; i < 4; i++) if (a[i]) return 1;
    return 0;
  endfunction

  function automatic int modelSummary();
    return int'(anyOf(mPen)) + 2 * int'(anyOf(mPg)) + 4 * int'(anyOf(mOc)) +
           8 * int'(anyOf(mLd)) + 16 * int'(anyOf(mTo)) + 32 * int'(anyOf(mSup));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        mPg[i] = 0; mPen[i] = 0; mLd[i] = 0; mOc[i] = 0; mTo[i] = 0; mSup[i] = 0;
        lastPg[i] = 0; lastPen[i] = 0;
      end
      mMask = 0; mRd = 0;
    end else begin
      bit clrP, clrF, clrT;
      clrP = 0; clrF = 0; clrT = 0;
      if (rdEn) begin
        case (rdAddr)
          8'h00: mRd = modelSummary();
          8'h01: mRd = mMask;
          8'h02: mRd = packPair(mPg, mPen);
          8'h03: begin mRd = packPair(mPg, mPen); clrP = 1; end
          8'h04: mRd = packPair(mLd, mOc);
          8'h05: begin mRd = packPair(mLd, mOc); clrF = 1; end
          8'h06: mRd = packPair(mSup, mTo);
          8'h07: begin mRd = packPair(mSup, mTo); clrT = 1; end
          default: mRd = 0;
        endcase
      end
      if (wrEn && wrAddr == 8'h1A && wrData[7]) begin clrP = 1; clrF = 1; clrT = 1; end
      if (wrEn && wrAddr == 8'h01) mMask = int'(wrData);
      for (int i = 0; i < 4; i++) begin
        if (clrP) begin mPg[i] = 0; mPen[i] = 0; end
        if (clrF) begin mLd[i] = 0; mOc[i] = 0; end
        if (clrT) begin mTo[i] = 0; mSup[i] = 0; end
        if (pgIn[i] != lastPg[i])   mPg[i] = 1;
        if (penIn[i] != lastPen[i]) mPen[i] = 1;
        if (ldDiscStb[i])   mLd[i] = 1;
        if (ocFltStb[i])    mOc[i] = 1;
        if (startTmoStb[i]) mTo[i] = 1;
        if (supFltStb[i])   mSup[i] = 1;
        lastPg[i] = pgIn[i];
        lastPen[i] = penIn[i];
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      total++;
      if (int'(rdData) != mRd) begin
        bad++;
        $display("FAIL R12 model rdData actual=%h expected=%h", rdData, mRd[7:0]);
      end
      total++;
      if (irqLine !== (((modelSummary() & mMask) != 0) ? 1'b0 : 1'b1)) begin
        bad++;
        $display("FAIL R8 model irq actual=%b expected=%b", irqLine,
                 ((modelSummary() & mMask) != 0) ? 1'b0 : 1'b1);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readExpect(input logic [7:0] a, input int exp, input string req);
    rdEn = 1'b1; rdAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
    check(int'(rdData) == exp, req, int'(rdData), exp);
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic checkIrq(input logic exp, input string req);
    check(irqLine === exp, req, int'(irqLine), int'(exp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    readExpect(8'h00, 0, "R11 summary after reset");
    readExpect(8'h01, 0, "R11 mask after reset");
    readExpect(8'h02, 0, "R11 power events after reset");
    checkIrq(1'b1, "R11 irq released");

    // R1 rising power-good on port 1
    pgIn[1] = 1'b1; @(negedge clk);
    readExpect(8'h02, 8'h20, "R1 pg rise");
    readExpect(8'h02, 8'h20, "R3 read-only keeps");
    readExpect(8'h03, 8'h20, "R3 clear-on-read returns");
    readExpect(8'h02, 8'h00, "R3 cleared");
    // R1 falling edge
    pgIn[1] = 1'b0; @(negedge clk);
    readExpect(8'h03, 8'h20, "R1 pg fall");
    // R2 power-enable change, both directions
    penIn[2] = 1'b1; @(negedge clk);
    readExpect(8'h03, 8'h04, "R2 pen rise");
    penIn[2] = 1'b0; @(negedge clk);
    readExpect(8'h03, 8'h04, "R2 pen fall");

    // R4 / R5 fault strobes
    ldDiscStb[3] = 1'b1; @(negedge clk); ldDiscStb = '0;
    readExpect(8'h04, 8'h80, "R4 load removal");
    ocFltStb[0] = 1'b1; @(negedge clk); ocFltStb = '0;
    readExpect(8'h04, 8'h81, "R5 overcurrent");
    readExpect(8'h05, 8'h81, "R5 clear-on-read fault");
    readExpect(8'h04, 8'h00, "R4 fault cleared");

    // R6 timeout and supply
    startTmoStb[2] = 1'b1; supFltStb[1] = 1'b1; @(negedge clk);
    startTmoStb = '0; supFltStb = '0;
    readExpect(8'h06, 8'h24, "R6 timeout/supply");
    readExpect(8'h00, 8'h30, "R7 summary bits");
    checkIrq(1'b1, "R8 masked stays released");

    // R8 mask
    writeReg(8'h01, 8'h10);
    checkIrq(1'b0, "R8 unmasked asserts");
    readExpect(8'h01, 8'h10, "R8 mask readback");
    readExpect(8'h07, 8'h24, "R6 clear-on-read timeout");
    checkIrq(1'b1, "R8 released after clear");

    // R10 event in the same cycle as clear-on-read
    penIn[0] = 1'b1; @(negedge clk);
    rdEn = 1'b1; rdAddr = 8'h03; pgIn[0] = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    check(rdData == 8'h01, "R10 clearing read returns old", int'(rdData), 8'h01);
    readExpect(8'h02, 8'h10, "R10 new event survives clear-on-read");

    // R9 global clear
    writeReg(8'h1A, 8'h7F);
    readExpect(8'h02, 8'h10, "R9 bit7 clear has no effect");
    wrEn = 1'b1; wrAddr = 8'h1A; wrData = 8'h80; ldDiscStb[1] = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; ldDiscStb = '0;
    readExpect(8'h02, 8'h00, "R9 global clear");
    readExpect(8'h04, 8'h20, "R10 event survives global clear");
    readExpect(8'h00, 8'h08, "R7 summary after global clear");

    // R12 unmapped
    readExpect(8'h1A, 0, "R12 unmapped command address");
    readExpect(8'h55, 0, "R12 unmapped high address");
    repeat (2) @(negedge clk);
    check(rdData == 8'h00, "R12 data holds", int'(rdData), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule